// File: doc/BRIEF.md
# Access-Width Packing FIFO Port

This block sits between a processor register port and the transmit and receive FIFOs of an SPI controller. It lets one register access carry several SPI data items, so software that moves a burst of short items needs fewer bus accesses. For each access it reads the access size (byte, halfword or word), the configured item width, the controller role, the peripheral-select mode and the two FIFO ready-threshold settings. From these it works out how many items to move. It then issues a single push or pop strobe together with an item count, so the FIFO can move its pointers by that count in one step.

Writes are split into 16-bit lanes, one item per lane. Reads are packed into 8-bit lanes when the items are 8 bits wide and the controller is in multi-item receive mode, and into 16-bit lanes otherwise. The first item always sits in the least significant lane. The receive FIFO shows its first four entries on a peek bus. Both FIFOs report their occupancy: free entries for transmit and stored entries for receive. Every output is registered and is valid in the cycle after the access is presented.

Top module: `spi_pack_port`

## Requirements
- R1: A byte access (size code 0) moves exactly one item in bits [7:0]. This holds for reads and writes, in every mode.
- R2: Multi-item transmit is enabled when the transmit threshold is nonzero and the variable-select flag is 0. In that mode a halfword write (size code 1) pushes one item taken from bits [15:0], and a word write (size code 2) pushes up to two items, the first from bits [15:0] and the second from bits [31:16].
- R3: When multi-item transmit is not enabled (threshold 0 or variable-select flag 1), every write pushes exactly one item, taken from the low bits.
- R4: Multi-item receive is enabled when the receive threshold is nonzero and the role input is 1 (client). In that mode, with 8-bit items, a halfword read pops up to two items and a word read pops up to four. Item k is returned in bits [8k+7:8k].
- R5: In multi-item receive mode with items wider than 8 bits, a halfword read pops one item and a word read pops up to two. Item k is returned in bits [16k+15:16k].
- R6: When multi-item receive is not enabled, every read pops one item and returns it in the low bits.
- R7: A read pops no more items than the receive FIFO holds. Lanes left unused read as zero. A read from an empty FIFO pops nothing and returns zero.
- R8: A write pushes no more items than the free space allows. If the access carried more items than fit, the overflow output is high in the same cycle as the (possibly empty) push.
- R9: Push, pop, overflow and read-valid appear in the cycle after the access and last for one cycle. An active strobe carries a count from 1 to 4. Without an access all strobes stay low and the data outputs read zero.
- R10: While reset is asserted, every output is zero.
- R11: With 8-bit items, each pushed or returned item carries only its low 8 bits and the upper bits of its lane are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Register access present this cycle |
| acc_write_i | input | 1 | 1 = write to transmit side, 0 = read from receive side |
| acc_size_i | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| acc_wdata_i | input | 32 | Write data, right-aligned |
| cfg_narrow_i | input | 1 | 1 = items are 8 bits wide |
| cfg_client_i | input | 1 | 1 = controller in client role |
| cfg_var_sel_i | input | 1 | 1 = variable peripheral-select mode |
| cfg_tx_thr_i | input | THR_W | Transmit ready-threshold setting |
| cfg_rx_thr_i | input | THR_W | Receive ready-threshold setting |
| tx_free_i | input | LVL_W | Free entries in the transmit FIFO |
| rx_level_i | input | LVL_W | Stored entries in the receive FIFO |
| rx_peek_i | input | 4*ITEM_W | First four receive entries, entry 0 lowest |
| tx_push_o | output | 1 | Push strobe |
| tx_push_cnt_o | output | 3 | Items pushed |
| tx_push_data_o | output | 2*ITEM_W | Pushed items, item 0 lowest |
| tx_ovf_o | output | 1 | Write carried more items than fit |
| rx_pop_o | output | 1 | Pop strobe |
| rx_pop_cnt_o | output | 3 | Items popped |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Packed read data |

## Verification
A behavioural model in the bench keeps the receive FIFO as a queue and compares every output on every clock. First, six 8-bit items are drained by one word read and one halfword read; this tells 8-bit lane packing apart from 16-bit lane packing. Next, 16-bit items are read with fewer entries stored than the access could carry, and then from an empty FIFO. These cases show whether unused lanes are zeroed and whether the pop count is clipped. Writes are tried with each eligibility condition broken in turn and with free space of 0 and 1, which separates the single-item fallback from the overflow clipping. A seeded random phase then mixes sizes, roles, widths and occupancies.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
  parameter int unsigned BUS_W  = 32;
  parameter int unsigned LANE_W = 16;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/spi_pack_elig.sv
module spi_pack_elig #(
  parameter int unsigned THR_W = 2
) (
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic             client_i,
  input  logic             var_sel_i,
  output logic             tx_multi_o,
  output logic             rx_multi_o
);
  assign tx_multi_o = (tx_thr_i != '0) && !var_sel_i;
  assign rx_multi_o = (rx_thr_i != '0) && client_i;
endmodule

// File: rtl/spi_pack_tx.sv
module spi_pack_tx
  import spi_pack_pkg::*;
#(
  parameter int unsigned ITEM_W = 16,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned MAX_WR = BUS_W / LANE_W
) (
  input  acc_size_e                 size_i,
  input  logic [BUS_W-1:0]          wdata_i,
  input  logic                      narrow_i,
  input  logic                      multi_i,
  input  logic [LVL_W-1:0]          free_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic [MAX_WR*ITEM_W-1:0]  data_o,
  output logic                      ovf_o
);
  logic [CNT_W-1:0]  cap;
  logic [ITEM_W-1:0] item_mask;

  always_comb begin
    cap = CNT_W'(1);
    if (multi_i && (size_i == ACC_WORD || size_i == ACC_RSVD)) cap = CNT_W'(MAX_WR);
    if (int'(free_i) < int'(cap)) begin
      cnt_o = CNT_W'(free_i);
      ovf_o = 1'b1;
    end else begin
      cnt_o = cap;
      ovf_o = 1'b0;
    end
    item_mask = (narrow_i || size_i == ACC_BYTE) ? ITEM_W'(8'hff) : '1;
  end

  for (genvar k = 0; k < MAX_WR; k++) begin : g_lane
    assign data_o[k*ITEM_W +: ITEM_W] =
      (CNT_W'(k) < cnt_o) ? (wdata_i[k*LANE_W +: ITEM_W] & item_mask) : '0;
  end
endmodule

// File: rtl/spi_pack_rx.sv
module spi_pack_rx
  import spi_pack_pkg::*;
#(
  parameter int unsigned ITEM_W = 16,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned MAX_RD = BUS_W / 8
) (
  input  acc_size_e                 size_i,
  input  logic                      narrow_i,
  input  logic                      multi_i,
  input  logic [LVL_W-1:0]          level_i,
  input  logic [MAX_RD*ITEM_W-1:0]  peek_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic [BUS_W-1:0]          rdata_o
);
  localparam int unsigned NW = BUS_W / LANE_W;

  logic              lane8;
  logic [CNT_W-1:0]  cap;
  logic [ITEM_W-1:0] item_mask;
  logic [BUS_W-1:0]  pk8, pk16, full;

  assign lane8     = multi_i && narrow_i;
  assign item_mask = narrow_i ? ITEM_W'(8'hff) : '1;

  always_comb begin
    unique case (size_i)
      ACC_BYTE: cap = CNT_W'(1);
      ACC_HALF: cap = lane8 ? CNT_W'(2) : CNT_W'(1);
      default:  cap = !multi_i ? CNT_W'(1) : (narrow_i ? CNT_W'(MAX_RD) : CNT_W'(NW));
    endcase
    cnt_o = (int'(level_i) < int'(cap)) ? CNT_W'(level_i) : cap;
  end

  for (genvar k = 0; k < MAX_RD; k++) begin : g_n8
    assign pk8[k*8 +: 8] = (CNT_W'(k) < cnt_o) ? peek_i[k*ITEM_W +: 8] : 8'h00;
  end

  for (genvar k = 0; k < NW; k++) begin : g_n16
    assign pk16[k*LANE_W +: LANE_W] =
      (CNT_W'(k) < cnt_o) ? LANE_W'(peek_i[k*ITEM_W +: ITEM_W] & item_mask) : '0;
  end

  always_comb begin
    full = lane8 ? pk8 : pk16;
    unique case (size_i)
      ACC_BYTE: rdata_o = full & BUS_W'(32'h0000_00ff);
      ACC_HALF: rdata_o = full & BUS_W'(32'h0000_ffff);
      default:  rdata_o = full;
    endcase
  end
endmodule

// File: rtl/spi_pack_port.sv
module spi_pack_port
  import spi_pack_pkg::*;
#(
  parameter int unsigned ITEM_W     = 16,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned THR_W      = 2,
  localparam int unsigned LVL_W  = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned CNT_W  = 3,
  localparam int unsigned MAX_WR = BUS_W / LANE_W,
  localparam int unsigned MAX_RD = BUS_W / 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_valid_i,
  input  logic                     acc_write_i,
  input  logic [1:0]               acc_size_i,
  input  logic [BUS_W-1:0]         acc_wdata_i,
  input  logic                     cfg_narrow_i,
  input  logic                     cfg_client_i,
  input  logic                     cfg_var_sel_i,
  input  logic [THR_W-1:0]         cfg_tx_thr_i,
  input  logic [THR_W-1:0]         cfg_rx_thr_i,
  input  logic [LVL_W-1:0]         tx_free_i,
  input  logic [LVL_W-1:0]         rx_level_i,
  input  logic [MAX_RD*ITEM_W-1:0] rx_peek_i,
  output logic                     tx_push_o,
  output logic [CNT_W-1:0]         tx_push_cnt_o,
  output logic [MAX_WR*ITEM_W-1:0] tx_push_data_o,
  output logic                     tx_ovf_o,
  output logic                     rx_pop_o,
  output logic [CNT_W-1:0]         rx_pop_cnt_o,
  output logic                     rd_valid_o,
  output logic [BUS_W-1:0]         rd_data_o
);
  acc_size_e                 size;
  logic                      tx_multi, rx_multi;
  logic [CNT_W-1:0]          tx_cnt, rx_cnt;
  logic [MAX_WR*ITEM_W-1:0]  tx_data;
  logic                      tx_ovf;
  logic [BUS_W-1:0]          rx_data;
  logic                      do_wr, do_rd;

  assign size  = acc_size_e'(acc_size_i);
  assign do_wr = acc_valid_i && acc_write_i;
  assign do_rd = acc_valid_i && !acc_write_i;

  spi_pack_elig #(.THR_W(THR_W)) u_elig (
    .tx_thr_i  (cfg_tx_thr_i),
    .rx_thr_i  (cfg_rx_thr_i),
    .client_i  (cfg_client_i),
    .var_sel_i (cfg_var_sel_i),
    .tx_multi_o(tx_multi),
    .rx_multi_o(rx_multi)
  );

  spi_pack_tx #(.ITEM_W(ITEM_W), .LVL_W(LVL_W), .CNT_W(CNT_W), .MAX_WR(MAX_WR)) u_tx (
    .size_i  (size),
    .wdata_i (acc_wdata_i),
    .narrow_i(cfg_narrow_i),
    .multi_i (tx_multi),
    .free_i  (tx_free_i),
    .cnt_o   (tx_cnt),
    .data_o  (tx_data),
    .ovf_o   (tx_ovf)
  );

  spi_pack_rx #(.ITEM_W(ITEM_W), .LVL_W(LVL_W), .CNT_W(CNT_W), .MAX_RD(MAX_RD)) u_rx (
    .size_i  (size),
    .narrow_i(cfg_narrow_i),
    .multi_i (rx_multi),
    .level_i (rx_level_i),
    .peek_i  (rx_peek_i),
    .cnt_o   (rx_cnt),
    .rdata_o (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_push_o      <= 1'b0;
      tx_push_cnt_o  <= '0;
      tx_push_data_o <= '0;
      tx_ovf_o       <= 1'b0;
      rx_pop_o       <= 1'b0;
      rx_pop_cnt_o   <= '0;
      rd_valid_o     <= 1'b0;
      rd_data_o      <= '0;
    end else begin
      tx_push_o      <= do_wr && (tx_cnt != '0);
      tx_push_cnt_o  <= do_wr ? tx_cnt : '0;
      tx_push_data_o <= do_wr ? tx_data : '0;
      tx_ovf_o       <= do_wr && tx_ovf;
      rx_pop_o       <= do_rd && (rx_cnt != '0);
      rx_pop_cnt_o   <= do_rd ? rx_cnt : '0;
      rd_valid_o     <= do_rd;
      rd_data_o      <= do_rd ? rx_data : '0;
    end
  end

  // R9
  no_idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acc_valid_i) |-> !tx_push_o && !rx_pop_o && !tx_ovf_o && !rd_valid_o);

  // R9
  pop_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (rx_pop_cnt_o != '0) && (rx_pop_cnt_o <= CNT_W'(MAX_RD)));

  // R7
  pop_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> int'(rx_pop_cnt_o) <= int'($past(rx_level_i)));

  // R8
  push_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> int'(tx_push_cnt_o) <= int'($past(tx_free_i)));

  // R8
  ovf_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |-> $past(acc_valid_i && acc_write_i));

  // R1
  byte_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc_valid_i && acc_size_i == 2'd0) && (tx_push_o || rx_pop_o)
      |-> (tx_push_cnt_o == CNT_W'(1)) || (rx_pop_cnt_o == CNT_W'(1)));

  // R3
  tx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o && $past(!tx_multi) |-> tx_push_cnt_o == CNT_W'(1));

  // R6
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o && $past(!rx_multi) |-> rx_pop_cnt_o == CNT_W'(1));
endmodule

// File: tb/spi_pack_port_tb.sv
module spi_pack_port_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [1:0]  acc_size_i = 2'd0;
  logic [31:0] acc_wdata_i = '0;
  logic        cfg_narrow_i = 1'b0, cfg_client_i = 1'b0, cfg_var_sel_i = 1'b0;
  logic [1:0]  cfg_tx_thr_i = '0, cfg_rx_thr_i = '0;
  logic [4:0]  tx_free_i = '0, rx_level_i = '0;
  logic [63:0] rx_peek_i = '0;
  logic        tx_push_o, tx_ovf_o, rx_pop_o, rd_valid_o;
  logic [2:0]  tx_push_cnt_o, rx_pop_cnt_o;
  logic [31:0] tx_push_data_o, rd_data_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] rxq[$];

  int          e_push, e_pcnt, e_ovf, e_pop, e_rcnt, e_rval;
  logic [31:0] e_pdata, e_rdata;
  string       tag;

  spi_pack_port u_dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic load_peek();
    rx_level_i = 5'(rxq.size() > DEPTH ? DEPTH : rxq.size());
    for (int k = 0; k < 4; k++)
      rx_peek_i[k*16 +: 16] = (k < rxq.size()) ? rxq[k] : 16'h0;
  endtask

  task automatic calc();
    int cap, n, lane, multi;
    longint imask;
    e_push = 0; e_pcnt = 0; e_ovf = 0; e_pop = 0; e_rcnt = 0; e_rval = 0;
    e_pdata = '0; e_rdata = '0; tag = "R9";
    if (!acc_valid_i) return;
    if (acc_write_i) begin
      multi = (cfg_tx_thr_i != 0) && !cfg_var_sel_i;
      cap = (multi && acc_size_i >= 2) ? 2 : 1;
      n = (tx_free_i < cap) ? int'(tx_free_i) : cap;
      e_ovf = (tx_free_i < cap);
      e_pcnt = n; e_push = (n > 0);
      imask = (cfg_narrow_i || acc_size_i == 0) ? 'hff : 'hffff;
      for (int k = 0; k < n; k++)
        e_pdata |= 32'(((acc_wdata_i >> (16*k)) & imask) << (16*k));
      if (acc_size_i == 0) tag = "R1";
      else if (e_ovf) tag = "R8";
      else if (!multi) tag = "R3";
      else if (cfg_narrow_i) tag = "R11";
      else tag = "R2";
    end else begin
      multi = (cfg_rx_thr_i != 0) && cfg_client_i;
      lane = (multi && cfg_narrow_i) ? 8 : 16;
      if (acc_size_i == 0) cap = 1;
      else if (acc_size_i == 1) cap = (lane == 8) ? 2 : 1;
      else cap = !multi ? 1 : (cfg_narrow_i ? 4 : 2);
      n = (rx_level_i < cap) ? int'(rx_level_i) : cap;
      e_rcnt = n; e_pop = (n > 0); e_rval = 1;
      imask = cfg_narrow_i ? 'hff : 'hffff;
      for (int k = 0; k < n; k++)
        e_rdata |= 32'((longint'(rxq[k]) & imask) << (lane*k));
      if (acc_size_i == 0) e_rdata &= 32'hff;
      else if (acc_size_i == 1) e_rdata &= 32'hffff;
      if (acc_size_i == 0) tag = "R1";
      else if (rx_level_i < cap) tag = "R7";
      else if (!multi) tag = "R6";
      else if (cfg_narrow_i) tag = "R4";
      else tag = "R5";
    end
  endtask

  task automatic compare();
    chk(tag, "push", tx_push_o, e_push);
    chk(tag, "push_cnt", tx_push_cnt_o, e_pcnt);
    chk(tag, "push_data", tx_push_data_o, e_pdata);
    chk(tag, "ovf", tx_ovf_o, e_ovf);
    chk(tag, "pop", rx_pop_o, e_pop);
    chk(tag, "pop_cnt", rx_pop_cnt_o, e_rcnt);
    chk(tag, "rd_valid", rd_valid_o, e_rval);
    chk(tag, "rd_data", rd_data_o, e_rdata);
  endtask

  task automatic step(bit v, bit w, logic [1:0] sz, logic [31:0] wd);
    acc_valid_i = v; acc_write_i = w; acc_size_i = sz; acc_wdata_i = wd;
    load_peek();
    calc();
    @(posedge clk_i);
    #2;
    compare();
    for (int k = 0; k < e_rcnt; k++) void'(rxq.pop_front());
    @(negedge clk_i);
    acc_valid_i = 1'b0;
  endtask

  task automatic cfg(bit nar, bit cli, bit vs, logic [1:0] tt, logic [1:0] rt);
    cfg_narrow_i = nar; cfg_client_i = cli; cfg_var_sel_i = vs;
    cfg_tx_thr_i = tt; cfg_rx_thr_i = rt;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_size_i = 2'd2; acc_wdata_i = '1;
    tx_free_i = 5'd4;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", "push", tx_push_o, 0);
    chk("R10", "push_data", tx_push_data_o, 0);
    chk("R10", "pop", rx_pop_o, 0);
    chk("R10", "rd_data", rd_data_o, 0);
    chk("R10", "rd_valid", rd_valid_o, 0);
    chk("R10", "ovf", tx_ovf_o, 0);
    acc_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(0, 0, 2'd2, 32'hffff_ffff);   // R9 idle

    // R4: six 8-bit items drained by word then halfword
    cfg(1, 1, 0, 2'd1, 2'd1);
    rxq = '{16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0055, 16'h0066};
    step(1, 0, 2'd2, '0);
    step(1, 0, 2'd1, '0);
    chk("R4", "queue_empty", rxq.size(), 0);

    // R11: 8-bit items stored with dirty upper byte
    rxq = '{16'hab12, 16'hcd34};
    step(1, 0, 2'd2, '0);

    // R5 / R7: 16-bit items, short queue, empty queue
    cfg(0, 1, 0, 2'd1, 2'd2);
    rxq = '{16'ha1b2, 16'hc3d4, 16'he5f6};
    step(1, 0, 2'd2, '0);
    step(1, 0, 2'd2, '0);
    step(1, 0, 2'd2, '0);
    rxq = '{16'h1357, 16'h2468};
    step(1, 0, 2'd1, '0);
    step(1, 0, 2'd0, '0);                // R1 byte read of 16-bit item

    // R6: host role disables multi receive
    cfg(0, 0, 0, 2'd1, 2'd1);
    rxq = '{16'h7777, 16'h8888};
    step(1, 0, 2'd2, '0);
    rxq.delete();

    // R2 / R1: transmit packing
    cfg(0, 1, 0, 2'd3, 2'd1);
    tx_free_i = 5'd8;
    step(1, 1, 2'd2, 32'h1234_5678);
    step(1, 1, 2'd1, 32'h1234_5678);
    step(1, 1, 2'd0, 32'h1234_5678);
    cfg(1, 1, 0, 2'd3, 2'd1);
    step(1, 1, 2'd2, 32'h1234_5678);     // R11

    // R3: variable select, then zero threshold
    cfg(0, 1, 1, 2'd2, 2'd1);
    step(1, 1, 2'd2, 32'hdead_beef);
    cfg(0, 1, 0, 2'd0, 2'd1);
    step(1, 1, 2'd2, 32'hdead_beef);

    // R8: overflow with one and zero free entries
    cfg(0, 1, 0, 2'd1, 2'd1);
    tx_free_i = 5'd1;
    step(1, 1, 2'd2, 32'hcafe_f00d);
    tx_free_i = 5'd0;
    step(1, 1, 2'd2, 32'hcafe_f00d);
    step(1, 1, 2'd0, 32'hcafe_f00d);
    step(0, 1, 2'd2, 32'hcafe_f00d);     // R9 pulse ends

    // mixed random phase
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      cfg(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
      tx_free_i = 5'($urandom_range(0, 4));
      while (rxq.size() < 6 && $urandom_range(0, 3) != 0) rxq.push_back(16'($urandom));
      step(1'($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom_range(0, 2)), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule